// File: doc/BRIEF.md
# Stepped Gain Attenuator with Soft Mute

This block scales a stream of signed 16-bit audio samples by a 6-bit gain code. The code is held in a saturating up/down counter, and each output equals the input times the code divided by 63, rounded to the nearest integer. A code of 63 passes the sample through unchanged. A code of 0 silences it.

The counter has two possible drive sources, and a mode input selects between them. In manual mode, each rising edge of a slow external step clock moves the code by one position. A direction input picks whether that move is up or down. In soft-mute mode the step clock is ignored. An internal timer counts sample-rate ticks and moves the code once every sixteen ticks. It moves down while the mute request is high and up while it is low, so a full sweep takes roughly 1024 sample periods. Any toggle of the mode input restores full gain. Reset also restores full gain.

The step clock is asynchronous to the system clock. It is brought into the system clock domain through a synchronizer and then edge-detected. Every other input is already in the system clock domain.

Top module: `gain_ramp_atten`

## Requirements
- R1: After reset the gain code is 63, the scaled output is 0 and the output strobe is low.
- R2: One clock after a cycle with the sample strobe high, the output strobe is high. The scaled output then equals the sample times the code divided by 63, with the magnitude rounded to nearest and the sign of the product kept.
- R3: In manual mode (mode input low), a rising edge of the step clock moves the code by exactly one. The move is down when the direction input is high and up when it is low. It takes effect within four system clocks of the edge.
- R4: The code saturates: a down step at 0 leaves 0, and an up step at 63 leaves 63.
- R5: Every change of the mode input, in either direction, reloads the code to 63 on the next clock.
- R6: In soft-mute mode (mode input high), edges on the step clock leave the code unchanged.
- R7: In soft-mute mode the code moves by one on every sixteenth sample tick counted from entry into the mode. It moves down while the mute input is high and up while it is low. A full descent from 63 to 0 therefore takes 1008 ticks.
- R8: With code 63 the output equals the input sample, and with code 0 the output is 0, for every sample value including -32768 and 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 16 | Signed input sample |
| sampleValid | input | 1 | Input sample strobe |
| softMode | input | 1 | High selects soft-mute mode, low selects manual mode |
| dirMute | input | 1 | Step direction in manual mode, mute request in soft-mute mode; high means down |
| stepClk | input | 1 | Asynchronous external step clock, used on rising edges |
| fsTick | input | 1 | One-cycle pulse per sample period |
| sampleOut | output | 16 | Signed scaled sample |
| outValid | output | 1 | Strobe marking a new scaled sample |
| gainCode | output | 6 | Current gain code |

## Verification
The assertions rely on three properties of the stimulus:
- the sample-rate tick lasts a single clock;
- the step clock holds each level for several system clocks, so the synchronizer never sees a rising edge less than two clocks after the previous one;
- the mode input is held at a known level through reset.

The bench meets these conditions by changing every input on a falling clock edge. It drives the step clock with four-cycle high and low phases and pulses the tick for exactly one cycle. The code is walked through every value from 63 down to 0, and a fixed set of extreme and mid-range samples is applied at each step.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;

  // Strobes from control to datapath; loadFull has priority over steps.
  typedef struct packed {
    logic loadFull;
    logic stepUp;
    logic stepDown;
  } gainCtrl_t;

endpackage

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
  import gain_ramp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAMP_DIV    = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      softMode,
  input  logic      dirMute,
  input  logic      stepClk,
  input  logic      fsTick,
  output gainCtrl_t ctrl
);

  localparam int TICK_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(RAMP_DIV - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   stepPrev;
  logic                   modePrev;
  logic [TICK_W-1:0]      tickCnt;
  logic                   stepRise;
  logic                   modeFlip;
  logic                   rampHit;
  logic                   manualStep;
  logic                   anyStep;

  // Synchronizer chain for the asynchronous step clock
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= stepClk;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], stepClk};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepPrev <= 1'b0;
      modePrev <= 1'b0;
    end else begin
      stepPrev <= syncQ[SYNC_STAGES-1];
      modePrev <= softMode;
    end
  end

  assign stepRise   = syncQ[SYNC_STAGES-1] & ~stepPrev;
  assign modeFlip   = softMode ^ modePrev;
  assign rampHit    = softMode & fsTick & (tickCnt == TICK_LAST);
  assign manualStep = ~softMode & stepRise;
  assign anyStep    = ~modeFlip & (manualStep | rampHit);

  // Ramp timer: counts sample ticks while in soft-mute mode
  always_ff @(posedge clk) begin
    if (!rstN || modeFlip || !softMode) begin
      tickCnt <= '0;
    end else if (fsTick) begin
      tickCnt <= rampHit ? '0 : tickCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.loadFull = modeFlip;
    ctrl.stepDown = anyStep & dirMute;
    ctrl.stepUp   = anyStep & ~dirMute;
  end

  // R3/R4 strobes never ask for both directions at once
  a_r3_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.stepUp, ctrl.stepDown}));

  // R6: in soft-mute mode only a sample tick may cause a step
  a_r6_soft_ignores_step_clock: assert property (@(posedge clk) disable iff (!rstN)
    (softMode && !fsTick) |-> !(ctrl.stepUp || ctrl.stepDown));

  // R5: a mode change never coincides with a step
  a_r5_reload_wins: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadFull |-> !(ctrl.stepUp || ctrl.stepDown));

endmodule

// File: rtl/gain_ramp_dp.sv
module gain_ramp_dp
  import gain_ramp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  gainCtrl_t                ctrl,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic                     sampleValid,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     outValid,
  output logic [CODE_W-1:0]        gainCode
);

  localparam int PROD_W = DATA_W + CODE_W + 1;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [PROD_W-1:0] FULL     = PROD_W'(2 ** CODE_W - 1);
  localparam logic [PROD_W-1:0] HALF     = PROD_W'((2 ** CODE_W - 1) / 2);

  logic signed [PROD_W-1:0] product;
  logic                     prodNeg;
  logic        [PROD_W-1:0] prodMag;
  logic        [PROD_W-1:0] quotMag;
  logic signed [PROD_W-1:0] quotSigned;
  logic signed [DATA_W-1:0] scaled;

  // Gain code counter with saturation
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.loadFull) begin
      gainCode <= CODE_MAX;
    end else if (ctrl.stepDown && gainCode != '0) begin
      gainCode <= gainCode - 1'b1;
    end else if (ctrl.stepUp && gainCode != CODE_MAX) begin
      gainCode <= gainCode + 1'b1;
    end
  end

  // Scale: round(|s*c| / full) with the sign of the product
  always_comb begin
    product    = PROD_W'(sampleIn) * $signed({1'b0, gainCode});
    prodNeg    = product[PROD_W-1];
    prodMag    = prodNeg ? -product : product;
    quotMag    = (prodMag + HALF) / FULL;
    quotSigned = prodNeg ? -$signed(quotMag) : $signed(quotMag);
    scaled     = quotSigned[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= sampleValid;
      if (sampleValid) sampleOut <= scaled;
    end
  end

  // R5: reload strobe forces full gain
  a_r5_full_after_reload: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadFull |=> gainCode == CODE_MAX);

  // R3: a down step moves the code by exactly one
  a_r3_down_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.stepDown && !ctrl.loadFull && gainCode != '0) |=> gainCode == $past(gainCode) - 1'b1);

  // R4: saturation at the bottom
  a_r4_floor_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.stepDown && !ctrl.loadFull && gainCode == '0) |=> gainCode == '0);

  // R4: saturation at the top
  a_r4_ceiling_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.stepUp && gainCode == CODE_MAX) |=> gainCode == CODE_MAX);

  // R8: zero gain gives silence
  a_r8_mute_is_zero: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && gainCode == '0) |=> sampleOut == '0);

  // R8: full gain passes the sample through
  a_r8_unity_passes: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && gainCode == CODE_MAX) |=> sampleOut == $past(sampleIn));

endmodule

// File: rtl/gain_ramp_atten.sv
module gain_ramp_atten
  import gain_ramp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RAMP_DIV    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic                     sampleValid,
  input  logic                     softMode,
  input  logic                     dirMute,
  input  logic                     stepClk,
  input  logic                     fsTick,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     outValid,
  output logic [CODE_W-1:0]        gainCode
);

  gainCtrl_t ctrl;

  gain_ramp_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .RAMP_DIV   (RAMP_DIV)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .softMode(softMode),
    .dirMute (dirMute),
    .stepClk (stepClk),
    .fsTick  (fsTick),
    .ctrl    (ctrl)
  );

  gain_ramp_dp #(
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .sampleIn   (sampleIn),
    .sampleValid(sampleValid),
    .sampleOut  (sampleOut),
    .outValid   (outValid),
    .gainCode   (gainCode)
  );

endmodule

// File: tb/sim_gain_ramp_atten.sv
module sim_gain_ramp_atten;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic               sampleValid = 1'b0;
  logic               softMode = 1'b0;
  logic               dirMute = 1'b0;
  logic               stepClk = 1'b0;
  logic               fsTick = 1'b0;
  logic signed [15:0] sampleOut;
  logic               outValid;
  logic [5:0]         gainCode;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  gain_ramp_atten u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .softMode(softMode), .dirMute(dirMute), .stepClk(stepClk), .fsTick(fsTick),
    .sampleOut(sampleOut), .outValid(outValid), .gainCode(gainCode)
  );

  always #5 clk = ~clk;

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      finishRun();
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int expScale(input int s, input int c);
    int p = s * c;
    if (p < 0) return -((-p + 31) / 63);
    return (p + 31) / 63;
  endfunction

  function automatic int sampleOf(input int k);
    case (k)
      0: return -32768;
      1: return 32767;
      2: return 0;
      3: return 1;
      4: return -1;
      5: return 31;
      6: return -32;
      7: return 63;
      8: return -63;
      9: return 100;
      default: return ((k * 7919) % 65536) - 32768;
    endcase
  endfunction

  task automatic stepPulse();
    @(negedge clk) stepClk = 1'b1;
    repeat (4) @(negedge clk);
    stepClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) fsTick = 1'b1;
    @(negedge clk) fsTick = 1'b0;
  endtask

  task automatic applySample(input int s, input string req);
    @(negedge clk);
    sampleIn = 16'(s);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check({req, " strobe"}, int'(outValid), 1);
    check(req, int'(sampleOut), expScale(s, int'(gainCode)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 code", int'(gainCode), 63);
    check("R1 out", int'(sampleOut), 0);
    check("R1 strobe", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: up step at 63 saturates
    dirMute = 1'b0;
    stepPulse();
    check("R4 ceiling", int'(gainCode), 63);

    // R2/R3/R8: sweep every code from 63 down to 0
    dirMute = 1'b1;
    for (int c = 63; c >= 0; c--) begin
      check("R3 manual down", int'(gainCode), c);
      for (int k = 0; k < 20; k++) begin
        if (c == 63 || c == 0) applySample(sampleOf(k), "R8");
        else                   applySample(sampleOf(k), "R2");
      end
      if (c > 0) stepPulse();
    end

    // R4: floor
    stepPulse();
    check("R4 floor", int'(gainCode), 0);
    // R3: manual up
    dirMute = 1'b0;
    stepPulse();
    check("R3 manual up", int'(gainCode), 1);
    stepPulse();
    check("R3 manual up", int'(gainCode), 2);

    // R5: entering soft mode reloads 63
    @(negedge clk) softMode = 1'b1;
    @(negedge clk);
    check("R5 enter soft", int'(gainCode), 63);

    // R7: ramp down once per 16 ticks
    dirMute = 1'b1;
    repeat (15) tick();
    check("R7 before 16th", int'(gainCode), 63);
    tick();
    check("R7 after 16th", int'(gainCode), 62);

    // R6: step clock ignored in soft mode
    stepPulse();
    stepPulse();
    check("R6 step ignored", int'(gainCode), 62);

    repeat (16 * 62 - 1) tick();
    check("R7 near bottom", int'(gainCode), 1);
    tick();
    check("R7 full ramp", int'(gainCode), 0);
    repeat (32) tick();
    check("R4 soft floor", int'(gainCode), 0);
    applySample(12345, "R8");

    // R7: ramp back up
    dirMute = 1'b0;
    repeat (16) tick();
    check("R7 ramp up", int'(gainCode), 1);
    applySample(-20000, "R2");
    repeat (32) tick();
    check("R7 ramp up", int'(gainCode), 3);

    // R5: leaving soft mode reloads 63
    @(negedge clk) softMode = 1'b0;
    @(negedge clk);
    check("R5 leave soft", int'(gainCode), 63);
    dirMute = 1'b1;
    stepPulse();
    check("R3 back to manual", int'(gainCode), 62);

    // R5: reload again after re-entry, even mid-ramp
    @(negedge clk) softMode = 1'b1;
    @(negedge clk);
    check("R5 re-enter", int'(gainCode), 63);
    repeat (16) tick();
    check("R7 restart phase", int'(gainCode), 62);

    finishRun();
  end

endmodule